// File: doc/BRIEF.md
# Conditional Branch Resolver and PC Sequencer

This block decides, once per instruction step, where a 16-bit-instruction processor fetches next. Each step presents the decoded branch kind, a 5-bit condition code, a 5-bit offset field, a register value usable as a jump target, the address of the current instruction and the three ALU flags. The block resolves the condition and produces the address of the next instruction. A redirect-pending indicator tells the fetch side that the instruction now being fetched is a delay slot.

Two branch forms exist. One is relative to the PC, with a signed word offset. The other is absolute, taking its target from a register. A taken branch never redirects at once. The block first steps to the following instruction, which is the delay slot. The redirect to the target comes on the next accepted step. A branch that arrives while a delay slot is being executed is treated as a no-op. Fetch and execution of instructions are outside this block.

The step input is a valid/ready stream. `step_ready` is tied high, so the block never applies back-pressure. A step is consumed on every clock edge where `step_valid` is high. The results are a registered output with a valid flag that is not back-pressured. When no step is accepted, the result registers hold their values.

Top module: `bru_seq`

## Requirements
- R1: Flags are packed as bit 0 = Z, bit 1 = C, bit 2 = N. Condition bit 0 set demands Z = 0. Condition bit 1 set demands Z = 1. A branch is taken only if every demanded condition holds.
- R2: Condition bit 4 picks the tested flag: N when it is 1, C when it is 0. Condition bit 2 set demands that flag be 0. Condition bit 3 set demands it be 1.
- R3: A condition code of 5'b00000 always takes the branch, whatever the flags.
- R4: For a relative branch (kind 2'b01), the offset field is a 5-bit two's-complement word count. The target is cur_pc + 2 + 2*offset, computed modulo 2^32.
- R5: For an absolute branch (kind 2'b10), the target is the register value with bit 0 cleared and every bit above bit 23 cleared.
- R6: A taken branch first gives next_pc = cur_pc + 2 with redirect_pending = 1. At the next accepted step, next_pc = the saved target and redirect_pending = 0.
- R7: When no branch is presented (kind 2'b00 or 2'b11), or the condition fails, the result is next_pc = cur_pc + 2 with redirect_pending = 0.
- R8: A step accepted while redirect_pending is 1 is a delay slot. Any branch it carries is ignored: its result is the saved target with redirect_pending = 0, whatever its kind, condition, offset or register.
- R9: step_ready is always 1. The results appear after the clock edge that accepts the step, and out_valid is 1 exactly when the previous edge accepted a step. Without an accepted step, next_pc and redirect_pending keep their values.
- R10: After reset, next_pc = 0, redirect_pending = 0 and out_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | A step is presented |
| step_ready | output | 1 | Always 1; the block never stalls |
| br_kind | input | 2 | 00 none, 01 relative, 10 absolute, 11 none |
| br_cond | input | 5 | Condition code |
| br_off | input | 5 | Signed word offset for relative branches |
| br_reg | input | 32 | Register value for absolute branches |
| cur_pc | input | 32 | Address of the instruction being stepped |
| flags | input | 3 | {N, C, Z} |
| out_valid | output | 1 | Result from the previous edge is fresh |
| next_pc | output | 32 | Address of the next instruction |
| redirect_pending | output | 1 | The next instruction is a delay slot |

## Verification
Every result is due one clock edge after the step that causes it. The redirect that follows a taken branch is due one edge after the next accepted step, however many idle cycles come in between. The bench drives each step on a falling edge and compares the outputs at the next falling edge, against a model that carries the pending target across idle cycles. Idle cycles are checked for unchanged outputs. Directed cases cover each condition bit, the extreme offsets and a branch inside a delay slot.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int COND_W = 5;
  localparam int FLAG_W = 3;

  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_REL  = 2'b01,
    BK_ABS  = 2'b10,
    BK_RSVD = 2'b11
  } br_kind_e;

  // flag bit positions used by the condition decode
  localparam int FZ = 0;
  localparam int FC = 1;
  localparam int FN = 2;
endpackage

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              pass
);
  logic sel_flag;
  logic [3:0] veto;

  always_comb begin
    sel_flag = cond[4] ? flags[FN] : flags[FC];
    veto[0]  = cond[0] &  flags[FZ];
    veto[1]  = cond[1] & ~flags[FZ];
    veto[2]  = cond[2] &  sel_flag;
    veto[3]  = cond[3] & ~sel_flag;
    pass     = ~|veto;
  end
endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int OFF_W    = 5,
  parameter int ABS_KEEP = 24
) (
  input  logic [1:0]       kind,
  input  logic [OFF_W-1:0] off,
  input  logic [PC_W-1:0]  reg_val,
  input  logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  target
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic [PC_W-1:0] abs_mask;
  logic [PC_W-1:0] rel_disp;
  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] abs_tgt;

  generate
    if (ABS_KEEP >= PC_W) begin : g_full
      assign abs_mask = {{(PC_W-1){1'b1}}, 1'b0};
    end else begin : g_trunc
      assign abs_mask = {{(PC_W-ABS_KEEP){1'b0}}, {(ABS_KEEP-1){1'b1}}, 1'b0};
    end
  endgenerate

  always_comb begin
    rel_disp = {{(PC_W-OFF_W-1){off[OFF_W-1]}}, off, 1'b0};
    rel_tgt  = pc + STEP + rel_disp;
    abs_tgt  = reg_val & abs_mask;
    target   = (kind == BK_ABS) ? abs_tgt : rel_tgt;
  end
endmodule

// File: rtl/bru_seq.sv
module bru_seq
  import bru_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int OFF_W    = 5,
  parameter int ABS_KEEP = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_valid,
  output logic              step_ready,
  input  logic [1:0]        br_kind,
  input  logic [COND_W-1:0] br_cond,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [PC_W-1:0]   br_reg,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [FLAG_W-1:0] flags,
  output logic              out_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic              redirect_pending
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic            cond_pass;
  logic [PC_W-1:0] tgt;
  logic            is_branch;
  logic            take;
  logic [PC_W-1:0] tgt_q;

  bru_cond u_cond (
    .cond  (br_cond),
    .flags (flags),
    .pass  (cond_pass)
  );

  bru_target #(.PC_W(PC_W), .OFF_W(OFF_W), .ABS_KEEP(ABS_KEEP)) u_tgt (
    .kind    (br_kind),
    .off     (br_off),
    .reg_val (br_reg),
    .pc      (cur_pc),
    .target  (tgt)
  );

  assign step_ready = 1'b1;

  always_comb begin
    is_branch = (br_kind == BK_REL) || (br_kind == BK_ABS);
    take      = is_branch && cond_pass && !redirect_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid        <= 1'b0;
      next_pc          <= '0;
      redirect_pending <= 1'b0;
      tgt_q            <= '0;
    end else begin
      out_valid <= step_valid;
      if (step_valid) begin
        if (redirect_pending) begin
          next_pc          <= tgt_q;
          redirect_pending <= 1'b0;
        end else begin
          next_pc          <= cur_pc + STEP;
          redirect_pending <= take;
          if (take) tgt_q <= tgt;
        end
      end
    end
  end

  // R3: an all-zero condition on a real branch outside a slot arms the slot
  a_r3_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !redirect_pending && is_branch && (br_cond == '0)
    |=> redirect_pending);

  // R7: a failed or absent branch just steps by one instruction
  a_r7_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !redirect_pending && (!is_branch || !cond_pass)
    |=> !redirect_pending && (next_pc == $past(cur_pc) + STEP));

  // R8: a step in the delay slot always ends the slot, branch or not
  a_r8_slot_ignores_branch: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && redirect_pending |=> !redirect_pending);

  // R6: entering the slot steps to the next instruction
  a_r6_slot_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redirect_pending) |-> next_pc == $past(cur_pc) + STEP);

  // R9: out_valid tracks acceptance, idle cycles hold the result
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |=> out_valid);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> !out_valid && $stable(next_pc) && $stable(redirect_pending));
endmodule

// File: tb/sim_bru_seq.sv
`timescale 1ns/1ps
module sim_bru_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_valid = 1'b0;
  logic        step_ready;
  logic [1:0]  br_kind = 2'b00;
  logic [4:0]  br_cond = 5'd0;
  logic [4:0]  br_off = 5'd0;
  logic [31:0] br_reg = 32'd0;
  logic [31:0] cur_pc = 32'd0;
  logic [2:0]  flags = 3'd0;
  logic        out_valid;
  logic [31:0] next_pc;
  logic        redirect_pending;

  int checks = 0;
  int errors = 0;
  int seed = 32'h5eed_0042;
  bit done = 1'b0;

  // model state
  logic        m_pend = 1'b0;
  logic [31:0] m_tgt = 32'd0;
  logic [31:0] m_pc = 32'd0;

  always #4 clk = ~clk;

  bru_seq u0 (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_ready(step_ready),
    .br_kind(br_kind), .br_cond(br_cond), .br_off(br_off), .br_reg(br_reg),
    .cur_pc(cur_pc), .flags(flags), .out_valid(out_valid), .next_pc(next_pc),
    .redirect_pending(redirect_pending)
  );

  function automatic bit f_pass(input logic [4:0] c, input logic [2:0] f);
    logic sel;
    sel = c[4] ? f[2] : f[1];
    return !(c[0] && f[0]) && !(c[1] && !f[0]) && !(c[2] && sel) && !(c[3] && !sel);
  endfunction

  function automatic logic [31:0] f_target(input logic [1:0] k, input logic [4:0] o,
                                           input logic [31:0] r, input logic [31:0] p);
    if (k == 2'b10) return r & 32'h00FF_FFFE;
    return p + 32'd2 + {{26{o[4]}}, o, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one step on a falling edge, check at the next falling edge
  task automatic step(input bit v, input logic [1:0] k, input logic [4:0] c,
                      input logic [4:0] o, input logic [31:0] r,
                      input logic [31:0] p, input logic [2:0] f, input string tag);
    logic [31:0] exp_pc;
    logic        exp_pend;
    step_valid = v; br_kind = k; br_cond = c; br_off = o; br_reg = r;
    cur_pc = p; flags = f;
    exp_pc = m_pc; exp_pend = m_pend;
    if (v) begin
      if (m_pend) begin
        exp_pc = m_tgt; exp_pend = 1'b0;
      end else begin
        exp_pc = p + 32'd2;
        exp_pend = (k == 2'b01 || k == 2'b10) && f_pass(c, f);
        if (exp_pend) m_tgt = f_target(k, o, r, p);
      end
    end
    @(negedge clk);
    check({tag, " next_pc"}, next_pc, exp_pc);
    check({tag, " pending"}, {31'd0, redirect_pending}, {31'd0, exp_pend});
    check("R9 out_valid", {31'd0, out_valid}, {31'd0, v});
    m_pc = exp_pc; m_pend = exp_pend;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    check("R10 reset next_pc", next_pc, 32'd0);
    check("R10 reset pending", {31'd0, redirect_pending}, 32'd0);
    check("R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R9 ready", {31'd0, step_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: always-taken relative, offset -16, then slot
    step(1, 2'b01, 5'b00000, 5'b10000, 0, 32'h0000_1000, 3'b111, "R3 R6 take");
    step(1, 2'b00, 0, 0, 0, 32'h0000_1002, 3'b000, "R4 R6 redirect");
    // R4: max positive offset
    step(1, 2'b01, 5'b00000, 5'b01111, 0, 32'h0000_2000, 3'b000, "R4 take");
    step(0, 2'b00, 0, 0, 0, 0, 0, "R9 idle");
    step(1, 2'b00, 0, 0, 0, 32'h0000_2002, 0, "R4 R6 redirect");
    // R5: absolute with high bits and bit 0
    step(1, 2'b10, 5'b00000, 0, 32'hFFAB_CDEF, 32'h0000_3000, 0, "R5 take");
    step(1, 2'b01, 5'b00000, 5'd3, 0, 32'h0000_3002, 0, "R8 slot branch");
    step(1, 2'b00, 0, 0, 0, 32'h00AB_CDEE, 0, "R7 after");
    // R1: Z tests
    step(1, 2'b01, 5'b00001, 5'd1, 0, 32'h100, 3'b001, "R1 zclr fail");
    step(1, 2'b01, 5'b00010, 5'd1, 0, 32'h200, 3'b000, "R1 zset fail");
    step(1, 2'b01, 5'b00010, 5'd1, 0, 32'h300, 3'b001, "R1 zset take");
    step(1, 2'b00, 0, 0, 0, 32'h302, 0, "R1 redirect");
    // R2: C vs N selection
    step(1, 2'b01, 5'b01000, 5'd2, 0, 32'h400, 3'b100, "R2 cset fail");
    step(1, 2'b01, 5'b11000, 5'd2, 0, 32'h500, 3'b100, "R2 nset take");
    step(1, 2'b00, 0, 0, 0, 32'h502, 0, "R2 redirect");
    step(1, 2'b01, 5'b00100, 5'd2, 0, 32'h600, 3'b010, "R2 cclr fail");
    // R7: reserved kind
    step(1, 2'b11, 5'b00000, 5'd2, 0, 32'h700, 0, "R7 reserved");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rp;
      rp = $urandom & 32'hFFFF_FFFE;
      step(($urandom % 8) != 0, 2'($urandom), 5'($urandom & (($urandom % 3 == 0) ? 32'h0 : 32'h1F)),
           5'($urandom), $urandom, rp, 3'($urandom), "R6 R7 R8 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule